// File: doc/BRIEF.md
# Per-Core Local Interrupt Unit

This block gathers the interrupt sources private to each processor core in a cluster. It handles five of them per core: the timer, the performance counter, the fast debug channel and two software interrupts. Each one can be masked, routed to one of several core interrupt pins, and read back as a masked pending vector.

Every core has its own set of registers: a control register, set-mask and clear-mask registers, a masked pending view, a software-pending register and one map register per source. Accesses go through a plain register port. The requester names itself on `acc_core`. Address bit 4 picks the window:

- With bit 4 clear, the access reaches the requester's own registers.
- With bit 4 set, the access reaches the core named in the requester's target-index register.

The result is one group of interrupt pins per core.

Each core's routable flags come from fixed configuration pins. When a core's external-controller mode bit is set, all five of its sources count as routable. A source that is not routable cannot be mapped and never drives a pin.

Top module: `lcl_irq_unit`

## Requirements
- R1: After reset, every mask, map register, software-pending bit, external-mode bit and target index is zero, and every interrupt pin is low.
- R2: A write to offset 4 (set-mask) sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Bit order for every source vector is timer 0, performance counter 1, fast debug 2, software 0 at bit 3, software 1 at bit 4. A read of offset 3 returns the mask.
- R3: A write to offset 5 (clear-mask) clears each mask bit whose write-data bit is 1, so writing all ones disables every source.
- R4: A read of offset 1 returns the pending vector ANDed with the mask. In the pending vector, bits 0..2 are the core's hardware pending inputs and bits 3..4 are its software-pending bits.
- R5: A write to offset 2 loads write-data bits 1:0 into the software-pending bits. They hold that value until offset 2 is written again, and a read of offset 2 returns them.
- R6: A read of offset 0 returns the external-mode bit in bit 0 and, in bits 1..4, the routable flags for timer, counter, debug channel and software. A write to offset 0 changes only bit 0.
- R7: A source is routable when its flag is set (the software flag covers both software sources) or when external mode is on. A source that is not routable drives no pin.
- R8: Map registers sit at offsets 8..12, one per source in bit order. Bit 7 is the map enable and bits 2:0 are the pin number. A write to the map register of a source that is not routable at that moment is ignored.
- R9: Offset 6 holds the requester's own target index in either window. Accesses with address bit 4 set reach the core held in that index, for every register other than offset 6.
- R10: Interrupt pin p of a core is high exactly when some source of that core is pending, masked in, routable and mapped with enable to pin p. The pin changes one clock after the state it depends on.
- R11: Read data appears on `rd_data_o` on the clock after the read request and holds until the next read. A write takes effect on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_core | input | CORE_W | Index of the requesting core |
| acc_addr | input | 5 | Bit 4 selects the other window; bits 3:0 are the register offset |
| acc_wdata | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| hw_pend_i | input | 3*NUM_CORES | Per-core hardware pending levels (timer, counter, debug channel) |
| rt_flags_i | input | 4*NUM_CORES | Per-core routable flags (timer, counter, debug channel, software) |
| irq_pin_o | output | NUM_CORES*2**PIN_W | Per-core interrupt pins |

## Verification
Register state changes on the edge that samples a write. A read issued in the next cycle therefore already sees the new value, and read data is due one edge after the request. Interrupt pins pass through one more register, so they are due one edge after the state that feeds them. The bench drives on falling edges and samples on the following falling edge. It also checks that a pin is still at its old value at the first falling edge after a mask write, and has moved at the second.

// File: rtl/lcl_irq_pkg.sv
package lcl_irq_pkg;
  localparam int SRC_N  = 5;
  localparam int HW_N   = 3;
  localparam int SW_N   = 2;
  localparam int FLAG_N = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int MAP_EN_BIT = 7;

  localparam logic [3:0] OFF_CTL    = 4'd0;
  localparam logic [3:0] OFF_PEND   = 4'd1;
  localparam logic [3:0] OFF_SWPEND = 4'd2;
  localparam logic [3:0] OFF_MASK   = 4'd3;
  localparam logic [3:0] OFF_SMASK  = 4'd4;
  localparam logic [3:0] OFF_RMASK  = 4'd5;
  localparam logic [3:0] OFF_TARGET = 4'd6;
  localparam logic [3:0] OFF_MAP0   = 4'd8;
endpackage

// File: rtl/lcl_core_regs.sv
module lcl_core_regs
  import lcl_irq_pkg::*;
#(
  parameter int PIN_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_off,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [HW_N-1:0]          hw_pend,
  input  logic [FLAG_N-1:0]        rt_flags,
  output logic                     ext_mode,
  output logic [SRC_N-1:0]         mask,
  output logic [SW_N-1:0]          swpend,
  output logic [SRC_N-1:0]         routable,
  output logic [SRC_N-1:0]         map_en,
  output logic [SRC_N*PIN_W-1:0]   map_pin,
  output logic [SRC_N-1:0]         masked_pend
);
  logic [SRC_N-1:0] pend_vec;

  always_comb begin
    pend_vec    = {swpend, hw_pend};
    masked_pend = pend_vec & mask;
    if (ext_mode) routable = '1;
    else          routable = {rt_flags[3], rt_flags[3], rt_flags[2], rt_flags[1], rt_flags[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_mode <= 1'b0;
      mask     <= '0;
      swpend   <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_CTL:    ext_mode <= wdata[0];
        OFF_SWPEND: swpend   <= wdata[SW_N-1:0];
        OFF_SMASK:  mask     <= mask | wdata[SRC_N-1:0];
        OFF_RMASK:  mask     <= mask & ~wdata[SRC_N-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_map
    logic hit;
    assign hit = wr_en && (wr_off == 4'(int'(OFF_MAP0) + g)) && routable[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_en[g]                 <= 1'b0;
        map_pin[g*PIN_W +: PIN_W] <= '0;
      end else if (hit) begin
        map_en[g]                 <= wdata[MAP_EN_BIT];
        map_pin[g*PIN_W +: PIN_W] <= wdata[PIN_W-1:0];
      end
    end

    assert_map_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == 4'(int'(OFF_MAP0) + g) && !routable[g])
      |=> ($stable(map_en[g]) && $stable(map_pin[g*PIN_W +: PIN_W])));
  end

  assert_smask_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SMASK)
    |=> ((mask & $past(wdata[SRC_N-1:0])) == $past(wdata[SRC_N-1:0])));

  assert_rmask_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_RMASK) |=> ((mask & $past(wdata[SRC_N-1:0])) == '0));

  assert_swpend_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_off == OFF_SWPEND) |=> $stable(swpend));
endmodule

// File: rtl/lcl_pin_route.sv
module lcl_pin_route
  import lcl_irq_pkg::*;
#(
  parameter int PIN_W = 3,
  localparam int NUM_PINS = 1 << PIN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_N-1:0]       masked_pend,
  input  logic [SRC_N-1:0]       routable,
  input  logic [SRC_N-1:0]       map_en,
  input  logic [SRC_N*PIN_W-1:0] map_pin,
  output logic [NUM_PINS-1:0]    pins_o
);
  logic [SRC_N-1:0]    live;
  logic [NUM_PINS-1:0] pins_d;

  always_comb begin
    live   = masked_pend & routable & map_en;
    pins_d = '0;
    for (int s = 0; s < SRC_N; s++)
      if (live[s]) pins_d[map_pin[s*PIN_W +: PIN_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pins_o <= '0;
    else        pins_o <= pins_d;
  end

  assert_quiet_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_pend == '0) |=> (pins_o == '0));

  assert_no_unrouted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (routable == '0) |=> (pins_o == '0));

  assert_pin_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pins_o) <= $countones($past(masked_pend))));
endmodule

// File: rtl/lcl_irq_unit.sv
module lcl_irq_unit
  import lcl_irq_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int PIN_W     = 3,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOTS    = 1 << CORE_W,
  localparam int NUM_PINS = 1 << PIN_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_we,
  input  logic [CORE_W-1:0]         acc_core,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic [DATA_W-1:0]         rd_data_o,
  input  logic [NUM_CORES*HW_N-1:0]   hw_pend_i,
  input  logic [NUM_CORES*FLAG_N-1:0] rt_flags_i,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_pin_o
);
  logic [CORE_W-1:0]      target_sel [SLOTS];
  logic [CORE_W-1:0]      tgt;
  logic                   tgt_ok, req_ok;
  logic [3:0]             off;
  logic [NUM_CORES-1:0]   wr_core;

  logic                   ext_a    [NUM_CORES];
  logic [SRC_N-1:0]       mask_a   [NUM_CORES];
  logic [SW_N-1:0]        sw_a     [NUM_CORES];
  logic [SRC_N-1:0]       rout_a   [NUM_CORES];
  logic [SRC_N-1:0]       men_a    [NUM_CORES];
  logic [SRC_N*PIN_W-1:0] mpin_a   [NUM_CORES];
  logic [SRC_N-1:0]       mpend_a  [NUM_CORES];

  always_comb begin
    off    = acc_addr[3:0];
    req_ok = int'(acc_core) < NUM_CORES;
    tgt    = acc_addr[ADDR_W-1] ? target_sel[acc_core] : acc_core;
    tgt_ok = req_ok && (int'(tgt) < NUM_CORES);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign wr_core[c] = acc_en && acc_we && tgt_ok && (int'(tgt) == c) && (off != OFF_TARGET);

    lcl_core_regs #(.PIN_W(PIN_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_core[c]), .wr_off(off), .wdata(acc_wdata),
      .hw_pend(hw_pend_i[c*HW_N +: HW_N]), .rt_flags(rt_flags_i[c*FLAG_N +: FLAG_N]),
      .ext_mode(ext_a[c]), .mask(mask_a[c]), .swpend(sw_a[c]), .routable(rout_a[c]),
      .map_en(men_a[c]), .map_pin(mpin_a[c]), .masked_pend(mpend_a[c])
    );

    lcl_pin_route #(.PIN_W(PIN_W)) route_i (
      .clk(clk), .rst_n(rst_n), .masked_pend(mpend_a[c]), .routable(rout_a[c]),
      .map_en(men_a[c]), .map_pin(mpin_a[c]), .pins_o(irq_pin_o[c*NUM_PINS +: NUM_PINS])
    );
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_target
    always_ff @(posedge clk) begin
      if (!rst_n) target_sel[s] <= '0;
      else if (acc_en && acc_we && req_ok && off == OFF_TARGET && int'(acc_core) == s)
        target_sel[s] <= acc_wdata[CORE_W-1:0];
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    int idx;
    rd_next = '0;
    idx     = int'(off) - int'(OFF_MAP0);
    if (off == OFF_TARGET) begin
      if (req_ok) rd_next[CORE_W-1:0] = target_sel[acc_core];
    end else if (tgt_ok) begin
      case (off)
        OFF_CTL:    rd_next[FLAG_N:0] = {rt_flags_i[int'(tgt)*FLAG_N +: FLAG_N], ext_a[tgt]};
        OFF_PEND:   rd_next[SRC_N-1:0] = mpend_a[tgt];
        OFF_SWPEND: rd_next[SW_N-1:0]  = sw_a[tgt];
        OFF_MASK:   rd_next[SRC_N-1:0] = mask_a[tgt];
        default:
          if (idx >= 0 && idx < SRC_N) begin
            rd_next[MAP_EN_BIT]   = men_a[tgt][idx];
            rd_next[PIN_W-1:0]    = mpin_a[tgt][idx*PIN_W +: PIN_W];
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= '0;
    else if (acc_en && !acc_we) rd_data_o <= rd_next;
  end

  assert_target_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && req_ok && off == OFF_TARGET)
    |=> (target_sel[$past(acc_core)] == $past(acc_wdata[CORE_W-1:0])));

  assert_one_core_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_core));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> $stable(rd_data_o));
endmodule

// File: tb/lcl_irq_unit_tb_top.sv
`timescale 1ns/1ps
module lcl_irq_unit_tb_top;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int NP = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_we = 1'b0;
  logic [0:0] acc_core = '0;
  logic [4:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rd_data_o;
  logic [NC*3-1:0] hw_pend_i = '0;
  logic [NC*4-1:0] rt_flags_i = '0;
  logic [NC*NP-1:0] irq_pin_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcl_irq_unit #(.NUM_CORES(NC), .PIN_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_core(acc_core),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data_o(rd_data_o),
    .hw_pend_i(hw_pend_i), .rt_flags_i(rt_flags_i), .irq_pin_o(irq_pin_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int core, int addr, int data);
    acc_en = 1; acc_we = 1; acc_core = 1'(core); acc_addr = 5'(addr); acc_wdata = 8'(data);
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(int core, int addr, output int val);
    acc_en = 1; acc_we = 0; acc_core = 1'(core); acc_addr = 5'(addr);
    @(negedge clk);
    acc_en = 0;
    val = int'(rd_data_o);
  endtask

  function automatic int pins_of(int core);
    return int'(irq_pin_o[core*NP +: NP]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    int map_m [NC][5];
    rt_flags_i = 8'hF_5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v);  check("R1 ctl", v, int'(rt_flags_i[c*4 +: 4]) << 1);
      rd(c, 3, v);  check("R1 mask", v, 0);
      rd(c, 2, v);  check("R1 swpend", v, 0);
      rd(c, 6, v);  check("R1 target", v, 0);
      for (int s = 0; s < 5; s++) begin
        rd(c, 8 + s, v); check("R1 map", v, 0);
        map_m[c][s] = 0;
      end
      check("R1 pins", pins_of(c), 0);
    end

    // R2 R3 R4: mask sweep with all sources pending
    for (int c = 0; c < NC; c++) begin
      hw_pend_i[c*3 +: 3] = 3'b111;
      wr(c, 2, 3);
      for (int m = 0; m < 32; m++) begin
        wr(c, 5, 31);
        rd(c, 3, v); check("R3 clear all", v, 0);
        wr(c, 4, m);
        rd(c, 3, v); check("R2 set mask", v, m);
        rd(c, 1, v); check("R4 masked pend", v, m);
        wr(c, 5, 5'h15);
        rd(c, 3, v); check("R3 partial clear", v, m & 5'h0A);
        wr(c, 4, 5'h01);
        rd(c, 3, v); check("R2 keep others", v, (m & 5'h0A) | 1);
      end
      // R4 R5: pending pattern sweep with full mask
      wr(c, 4, 31);
      for (int p = 0; p < 32; p++) begin
        hw_pend_i[c*3 +: 3] = 3'(p);
        wr(c, 2, p >> 3);
        rd(c, 1, v); check("R4 pend pattern", v, p);
        rd(c, 2, v); check("R5 swpend read", v, p >> 3);
      end
      hw_pend_i[c*3 +: 3] = '0;
      wr(c, 5, 31);
    end

    // R5: software pending holds across other writes
    wr(0, 2, 2);
    wr(0, 4, 3); wr(0, 5, 3); wr(0, 0, 0); wr(0, 8, 0);
    rd(0, 2, v); check("R5 hold", v, 2);
    wr(0, 2, 0);

    // R6: control write touches only bit 0
    wr(1, 0, 8'hFF);
    rd(1, 0, v); check("R6 ctl", v, (int'(rt_flags_i[4 +: 4]) << 1) | 1);
    wr(1, 0, 0);
    rd(1, 0, v); check("R6 ctl clear", v, int'(rt_flags_i[4 +: 4]) << 1);

    // R7 R8: routability sweep over flags and external mode, core 0
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 2; e++) begin
        rt_flags_i[3:0] = 4'(f);
        wr(0, 0, e);
        for (int s = 0; s < 5; s++) begin
          int fl;
          int d;
          fl = (s >= 3) ? ((f >> 3) & 1) : ((f >> s) & 1);
          d  = 8'h80 | ((f + s + e) & 7);
          wr(0, 8 + s, d);
          if (fl == 1 || e == 1) map_m[0][s] = d;
          rd(0, 8 + s, v); check("R8 map write", v, map_m[0][s]);
        end
      end
    end
    for (int s = 0; s < 5; s++) begin
      wr(0, 0, 1); wr(0, 8 + s, 0); map_m[0][s] = 0;
    end
    wr(0, 0, 0);

    // R9: other window
    wr(0, 6, 1);
    rd(0, 6, v); check("R9 target readback", v, 1);
    rd(1, 6, v); check("R9 target per requester", v, 0);
    wr(0, 16 + 4, 31);
    rd(1, 3, v); check("R9 other mask", v, 31);
    rd(0, 3, v); check("R9 own mask untouched", v, 0);
    rt_flags_i[7:4] = 4'hF;
    wr(0, 16 + 8 + 2, 8'h85);
    rd(1, 10, v); check("R9 other map", v, 8'h85);
    rd(0, 16 + 10, v); check("R9 other read", v, 8'h85);
    wr(0, 16 + 5, 31);
    rd(1, 3, v); check("R9 other clear", v, 0);
    wr(0, 16 + 10, 0);

    // R10 R11: pin sweep on core 1
    wr(1, 4, 31);
    for (int s = 0; s < 5; s++) begin
      for (int p = 0; p < NP; p++) begin
        wr(1, 8 + s, 8'h80 | p);
        if (s < 3) hw_pend_i[3 + s] = 1'b1;
        else wr(1, 2, 1 << (s - 3));
        @(negedge clk);
        check("R10 pin", pins_of(1), 1 << p);
        check("R10 other core quiet", pins_of(0), 0);
        wr(1, 5, 1 << s);
        check("R11 pin lags state", pins_of(1), 1 << p);
        @(negedge clk);
        check("R10 pin after unmask", pins_of(1), 0);
        wr(1, 4, 1 << s);
        hw_pend_i[5:3] = '0; wr(1, 2, 0);
        wr(1, 8 + s, p);
        @(negedge clk);
        check("R10 disabled map", pins_of(1), 0);
      end
    end

    // R7: routed source loses routability -> pin drops
    wr(1, 8, 8'h83);
    hw_pend_i[3] = 1'b1;
    @(negedge clk);
    check("R7 routed", pins_of(1), 8);
    rt_flags_i[4] = 1'b0;
    @(negedge clk);
    check("R7 unrouted", pins_of(1), 0);
    wr(1, 0, 1);
    @(negedge clk);
    check("R7 external mode", pins_of(1), 8);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule